// File: doc/BRIEF.md
# Output-Port Triggered Page-Select Unit

This unit sits beside a small processor core whose program counter is only 7 bits wide and extends its reach to sixteen 128-instruction pages of program memory. It watches the core's general output port and takes no dedicated instruction or bus signal. Software asks for a new page by writing a two-value trigger pattern to the port: first 4'hA, then 4'h5. It then places the wanted page number on the port. A fixed number of cycles after the trigger completes, the unit captures the port into its page register.

The page register is joined to the core's program counter to form the 11-bit program memory address. After it changes the page, software branches to the wanted location inside the new page. A port value counts as an event only in a cycle where it differs from the value of the previous cycle, so a value held for several cycles is seen once.

Top module: `pgsel_unit`

## Requirements
- R1: While `rst_ni` is low, and after it is released, the page register holds 0, so `addr_o` equals `{4'h0, pc_i}`.
- R2: `addr_o[10:7]` is the page register and `addr_o[6:0]` follows `pc_i` in the same cycle.
- R3: The trigger is 4'hA followed by 4'h5 as the next new port value. 4'hA may be held for any number of cycles before 4'h5 appears.
- R4: Take the cycle in which 4'h5 completes the trigger. The page register loads the port value present in the 4th cycle after it (parameter `DELAY_CYCLES`, default 4), and the new page appears in `addr_o` from the next cycle on. Before that cycle the old page is unchanged.
- R5: A new value other than 4'h5 that arrives after 4'hA cancels the trigger. A 4'h5 that is not directly preceded by a new 4'hA has no effect on the page.
- R6: After a cancelled trigger, a new 4'hA arms the detector again, and a following 4'h5 triggers normally.
- R7: While the delay runs, port changes are ignored by the detector. A full 4'hA, 4'h5 pattern inside the delay causes no second capture.
- R8: Detection resumes in the cycle after a capture, and a later trigger pattern changes the page again.
- R9: Port traffic that completes no trigger leaves the page register unchanged.
- R10: Only the port value in the final delay cycle is captured. Values written earlier in the delay are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_i | input | 4 | Core output port value |
| pc_i | input | 7 | Core program counter |
| addr_o | output | 11 | Program memory address {page, pc} |

## Verification
The trigger is tried in several forms: the plain two-value pattern, 4'hA held for several cycles, a pattern broken by a foreign value, a broken pattern re-armed by a second 4'hA, and a lone 4'h5. These cases separate correct edge-based detection from detectors that count cycles or fail to reset on a mismatch. A pattern replayed inside the delay window, with the port value changed in each delay cycle, shows whether the detector is blocked and whether the capture takes the final-cycle value rather than an earlier one. Every cycle compares the full address, so any capture one cycle early or late shows up as a miscompare, and so does a lost program-counter bit.

// File: rtl/pgsel_pkg.sv
package pgsel_pkg;
  typedef enum logic {
    DET_IDLE  = 1'b0,
    DET_ARMED = 1'b1
  } det_state_e;
endpackage

// File: rtl/pgsel_seq_detect.sv
module pgsel_seq_detect
  import pgsel_pkg::*;
#(
  parameter int unsigned         PORT_W      = 4,
  parameter logic [PORT_W-1:0]   FIRST_CODE  = 'hA,
  parameter logic [PORT_W-1:0]   SECOND_CODE = 'h5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] port_i,
  input  logic              hold_i,
  output logic              hit_o
);
  logic [PORT_W-1:0] prev_q;
  det_state_e        state_q, state_d;
  logic              new_val;

  assign new_val = (port_i != prev_q);

  always_comb begin
    state_d = state_q;
    hit_o   = 1'b0;
    if (!hold_i && new_val) begin
      unique case (state_q)
        DET_IDLE:  if (port_i == FIRST_CODE) state_d = DET_ARMED;
        DET_ARMED: begin
          if (port_i == SECOND_CODE) begin
            hit_o   = 1'b1;
            state_d = DET_IDLE;
          end else if (port_i == FIRST_CODE) begin
            state_d = DET_ARMED;
          end else begin
            state_d = DET_IDLE; // mismatch: value re-checked above as first element
          end
        end
        default: state_d = DET_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      state_q <= DET_IDLE;
    end else begin
      prev_q  <= port_i;
      state_q <= state_d;
    end
  end

  a_r5_hit_follows_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(port_i) == FIRST_CODE);
  a_r7_quiet_when_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |-> !hit_o);
endmodule

// File: rtl/pgsel_delay.sv
module pgsel_delay #(
  parameter int unsigned DELAY_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic fire_o
);
  localparam int unsigned CNT_W = $clog2(DELAY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;

  assign busy_o = active_q;
  assign fire_o = active_q && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (fire_o) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q) begin
      cnt_q    <= cnt_q + 1'b1;
    end
  end

  a_r7_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_i);
  a_r4_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o && cnt_q == '0);
  a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !busy_o);
  a_r4_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> cnt_q <= LAST);
endmodule

// File: rtl/pgsel_page.sv
module pgsel_page #(
  parameter int unsigned PORT_W = 4,
  parameter int unsigned PC_W   = 7,
  localparam int unsigned ADDR_W = PORT_W + PC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [PC_W-1:0]   pc_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [PORT_W-1:0] page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     page_q <= '0;
    else if (load_i) page_q <= port_i;
  end

  assign addr_o = {page_q, pc_i};

  a_r9_page_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(page_q));
  a_r10_page_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> page_q == $past(port_i));
endmodule

// File: rtl/pgsel_unit.sv
module pgsel_unit #(
  parameter int unsigned       PORT_W       = 4,
  parameter int unsigned       PC_W         = 7,
  parameter int unsigned       DELAY_CYCLES = 4,
  parameter logic [PORT_W-1:0] FIRST_CODE   = 'hA,
  parameter logic [PORT_W-1:0] SECOND_CODE  = 'h5,
  localparam int unsigned      ADDR_W       = PORT_W + PC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] port_i,
  input  logic [PC_W-1:0]   pc_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic hit, busy, fire;

  pgsel_seq_detect #(
    .PORT_W(PORT_W), .FIRST_CODE(FIRST_CODE), .SECOND_CODE(SECOND_CODE)
  ) u_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .port_i(port_i), .hold_i(busy), .hit_o(hit)
  );

  pgsel_delay #(.DELAY_CYCLES(DELAY_CYCLES)) u_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(hit), .busy_o(busy), .fire_o(fire)
  );

  pgsel_page #(.PORT_W(PORT_W), .PC_W(PC_W)) u_page (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(fire), .port_i(port_i),
    .pc_i(pc_i), .addr_o(addr_o)
  );

  a_r1_reset_page: assert property (@(posedge clk_i) !rst_ni |-> addr_o[ADDR_W-1:PC_W] == '0);
endmodule

// File: tb/pgsel_unit_test.sv
module pgsel_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  port = 4'h0;
  logic [6:0]  pc = 7'h55;
  logic [10:0] addr;

  int unsigned vectors = 0;
  int unsigned fails = 0;
  bit          done = 1'b0;

  logic [10:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  pgsel_unit uut (.clk_i(clk), .rst_ni(rst_ni), .port_i(port), .pc_i(pc), .addr_o(addr));

  task automatic cyc(input logic [3:0] p, input logic [3:0] ep, input string tag);
    @(posedge clk);
    #2;
    port = p;
    pc   = pc + 7'd1;
    exp_q.push_back({ep, pc});
    tag_q.push_back(tag);
  endtask

  // A, 5, then page value through the whole delay; new page from cycle after last delay cycle
  task automatic trig(input logic [3:0] pg, input logic [3:0] old, input string tag);
    cyc(4'hA, old, tag);
    cyc(4'h5, old, tag);
    repeat (4) cyc(pg, old, "R4");
    cyc(pg, pg, tag);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [10:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        vectors++;
        if (addr !== e) begin
          fails++;
          $display("FAIL %s: addr_o=%h expected %h", t, addr, e);
        end
      end
    end
  end

  initial begin : watchdog
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : driver
    #12;
    vectors++;
    if (addr !== {4'h0, 7'h55}) begin // R1 during reset
      fails++;
      $display("FAIL R1: addr_o=%h expected %h", addr, {4'h0, 7'h55});
    end
    @(negedge clk);
    rst_ni = 1'b1;

    cyc(4'h0, 4'h0, "R1");
    cyc(4'h3, 4'h0, "R9");
    cyc(4'h5, 4'h0, "R9");
    cyc(4'h1, 4'h0, "R2");
    trig(4'h3, 4'h0, "R3");
    // R3: first code held several cycles
    repeat (3) cyc(4'hA, 4'h3, "R3");
    cyc(4'h5, 4'h3, "R3");
    repeat (4) cyc(4'h9, 4'h3, "R4");
    cyc(4'h9, 4'h9, "R3");
    // R5: broken pattern
    cyc(4'hA, 4'h9, "R5");
    cyc(4'h7, 4'h9, "R5");
    cyc(4'h5, 4'h9, "R5");
    repeat (6) cyc(4'h5, 4'h9, "R5");
    // R6: re-arm after mismatch
    cyc(4'hA, 4'h9, "R6");
    cyc(4'h7, 4'h9, "R6");
    cyc(4'hA, 4'h9, "R6");
    cyc(4'h5, 4'h9, "R6");
    repeat (4) cyc(4'hC, 4'h9, "R4");
    cyc(4'hC, 4'hC, "R6");
    // R7 / R10: pattern inside the delay, last delay value wins
    cyc(4'hA, 4'hC, "R7");
    cyc(4'h5, 4'hC, "R7");
    cyc(4'hA, 4'hC, "R7");
    cyc(4'h5, 4'hC, "R7");
    cyc(4'h1, 4'hC, "R10");
    cyc(4'h6, 4'hC, "R10");
    cyc(4'h6, 4'h6, "R10");
    repeat (6) cyc(4'h6, 4'h6, "R7");
    // R8: detection resumes
    trig(4'hF, 4'h6, "R8");
    trig(4'h2, 4'hF, "R8");
    repeat (3) cyc(4'h2, 4'h2, "R9");

    @(negedge clk);
    #1;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule